// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical byte address. It holds four 16-bit segment bases. The access kind picks one of these bases by a fixed rule, and for some kinds an override selector can replace that choice. The physical address is the selected base shifted left by four bits plus the offset. The result wraps within the 20-bit address space.

The memory side is one byte wide. A byte access makes one request. A 16-bit word access makes two requests: the low byte at the offset, then the high byte at the offset plus one. Only the offset wraps inside the 64 KiB segment, and the word may start at any alignment. Each request is held until the memory acknowledges it. Read bytes are assembled into a word that is presented for one cycle once the final byte has returned.

A new access is accepted only while the block is idle. The segment bases are loaded through a simple write port.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset, acc_ready is 1, mem_req is 0, rd_valid is 0 and all four segment bases are zero.
- R2: Every request address equals (base × 16 + offset) modulo 2^20.
- R3: An instruction fetch (acc_kind 0) always uses the code base (selector 1), whatever the override inputs are.
- R4: Stack (acc_kind 1) and BP-relative (acc_kind 2) accesses use the stack base (selector 2) unless an override is given.
- R5: Data accesses (acc_kind 3, and the unused codes 5 to 7) use the data base (selector 3) unless an override is given.
- R6: A string destination (acc_kind 4) always uses the extra base (selector 0), whatever the override inputs are.
- R7: For kinds 1, 2, 3 and 5 to 7, ovr_en = 1 selects the base named by ovr_sel (0 extra, 1 code, 2 stack, 3 data).
- R8: A word access (acc_word = 1) makes two requests: first at the offset, then at (offset + 1) modulo 65536, both in the same segment.
- R9: While mem_req is 1 and mem_ack is 0, the request, mem_addr, mem_we and mem_wdata keep their values on the next cycle.
- R10: A read sets rd_valid for exactly the one cycle after its final acknowledge. rd_word then holds {high byte, low byte} for a word read, or the byte zero-extended for a byte read. A write never sets rd_valid.
- R11: A write drives mem_we = 1 and puts acc_wdata[7:0] on the first request and acc_wdata[15:8] on the second.
- R12: acc_ready is 1 only when no request is in progress. acc_valid has no effect while acc_ready is 0.
- R13: seg_wr_en = 1 loads seg_wr_data into the base named by seg_wr_sel. The new value is used by accesses accepted in later cycles, not by one accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Load a segment base |
| seg_wr_sel | input | 2 | Base to load (0 extra, 1 code, 2 stack, 3 data) |
| seg_wr_data | input | 16 | New base value |
| acc_valid | input | 1 | Access request |
| acc_ready | output | 1 | Block idle, access accepted when acc_valid is 1 |
| acc_kind | input | 3 | 0 fetch, 1 stack, 2 BP-relative, 3 data, 4 string destination |
| ovr_en | input | 1 | Segment override enable |
| ovr_sel | input | 2 | Override segment selector |
| acc_offset | input | 16 | Offset within the segment |
| acc_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 16 | Write data |
| mem_req | output | 1 | Byte request pending |
| mem_addr | output | 20 | Physical byte address |
| mem_we | output | 1 | Request is a write |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Memory accepts the current byte (read data valid) |
| mem_rdata | input | 8 | Read byte |
| rd_valid | output | 1 | Assembled read result valid |
| rd_word | output | 16 | Assembled read result |

## Verification
The hardest cases to reach are the ones where two independent wraps or two events in the same cycle decide the result. One is a word whose high byte wraps the offset back to the start of the segment. Another is a base near the top of memory whose sum overflows 20 bits. The third is a segment write that lands in the same cycle as an access being accepted. The bench sets a base of 0x4000 with offset 0xFFFF, and a base of 0xFFFF with a small offset. In one cycle it drives a data-base write together with acc_valid, then checks that the first request still uses the old base and that the next access uses the new one. Stalls made by withholding mem_ack are combined with a new acc_valid during the busy period, which shows that the held request does not change and that the extra request is dropped.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
    localparam int NUM_SEG = 4;
    localparam int SEL_W   = $clog2(NUM_SEG);

    typedef enum logic [SEL_W-1:0] {
        SEG_EXTRA = 2'd0,
        SEG_CODE  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_DATA  = 2'd3
    } seg_id_e;

    typedef enum logic [2:0] {
        KIND_FETCH  = 3'd0,
        KIND_STACK  = 3'd1,
        KIND_BPREL  = 3'd2,
        KIND_DATA   = 3'd3,
        KIND_STRDST = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LO   = 2'd1,
        SEQ_HI   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SEG_W-1:0] rd_base
);
    logic [SEG_W-1:0] base_d [NUM_SEG];
    logic [SEG_W-1:0] base_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        always_comb begin
            base_d[g] = base_q[g];
            if (wr_en && (wr_sel == SEL_W'(g))) begin
                base_d[g] = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
            end else begin
                base_q[g] <= base_d[g];
            end
        end
    end

    // read returns the registered value: a same-cycle write is not seen
    assign rd_base = base_q[rd_sel];
endmodule

// File: rtl/seg_select.sv
module seg_select
    import seg_addr_pkg::*;
(
    input  logic [2:0]       kind,
    input  logic             ovr_en,
    input  logic [SEL_W-1:0] ovr_sel,
    output logic [SEL_W-1:0] seg_sel
);
    logic fixed_kind;

    always_comb begin
        fixed_kind = 1'b0;
        case (kind)
            KIND_FETCH: begin
                seg_sel    = SEG_CODE;
                fixed_kind = 1'b1;
            end
            KIND_STRDST: begin
                seg_sel    = SEG_EXTRA;
                fixed_kind = 1'b1;
            end
            KIND_STACK, KIND_BPREL: seg_sel = SEG_STACK;
            default:                seg_sel = SEG_DATA;
        endcase
        if (ovr_en && !fixed_kind) begin
            seg_sel = ovr_sel;
        end
    end
endmodule

// File: rtl/phys_addr_calc.sv
module phys_addr_calc #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = 20
) (
    input  logic [SEG_W-1:0] base,
    input  logic [OFF_W-1:0] offset,
    output logic [PA_W-1:0]  paddr
);
    localparam int EXT_W = (SEG_W + SHIFT > OFF_W) ? SEG_W + SHIFT : OFF_W;

    logic [EXT_W-1:0] base_sh;
    logic [EXT_W-1:0] off_ext;
    logic [EXT_W-1:0] sum;

    always_comb begin
        base_sh = EXT_W'(base) << SHIFT;
        off_ext = EXT_W'(offset);
        sum     = base_sh + off_ext;
        paddr   = sum[PA_W-1:0];
    end
endmodule

// File: rtl/byte_sequencer.sv
module byte_sequencer
    import seg_addr_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    output logic                acc_ready,
    input  logic [SEG_W-1:0]    sel_base,
    input  logic [OFF_W-1:0]    acc_offset,
    input  logic                acc_word,
    input  logic                acc_write,
    input  logic [2*BYTE_W-1:0] acc_wdata,
    output logic [SEG_W-1:0]    cur_base,
    output logic [OFF_W-1:0]    cur_off,
    output logic                mem_req,
    output logic                mem_we,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic                rd_valid,
    output logic [2*BYTE_W-1:0] rd_word
);
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        seq_state_e        state;
        logic [SEG_W-1:0]  base;
        logic [OFF_W-1:0]  off;
        logic              word;
        logic              write;
        logic [WORD_W-1:0] wdata;
        logic [BYTE_W-1:0] lo_byte;
        logic              rd_valid;
        logic [WORD_W-1:0] rd_word;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = 1'b0;
        case (s_q.state)
            SEQ_IDLE: begin
                if (acc_valid) begin
                    s_d.base  = sel_base;
                    s_d.off   = acc_offset;
                    s_d.word  = acc_word;
                    s_d.write = acc_write;
                    s_d.wdata = acc_wdata;
                    s_d.state = SEQ_LO;
                end
            end
            SEQ_LO: begin
                if (mem_ack) begin
                    s_d.lo_byte = mem_rdata;
                    if (s_q.word) begin
                        s_d.off   = s_q.off + OFF_W'(1);
                        s_d.state = SEQ_HI;
                    end else begin
                        s_d.state = SEQ_IDLE;
                        if (!s_q.write) begin
                            s_d.rd_valid = 1'b1;
                            s_d.rd_word  = {{BYTE_W{1'b0}}, mem_rdata};
                        end
                    end
                end
            end
            SEQ_HI: begin
                if (mem_ack) begin
                    s_d.state = SEQ_IDLE;
                    if (!s_q.write) begin
                        s_d.rd_valid = 1'b1;
                        s_d.rd_word  = {mem_rdata, s_q.lo_byte};
                    end
                end
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_ready = (s_q.state == SEQ_IDLE);
    assign mem_req   = (s_q.state != SEQ_IDLE);
    assign mem_we    = mem_req && s_q.write;
    assign mem_wdata = (s_q.state == SEQ_HI) ? s_q.wdata[WORD_W-1:BYTE_W]
                                             : s_q.wdata[BYTE_W-1:0];
    assign cur_base  = s_q.base;
    assign cur_off   = s_q.off;
    assign rd_valid  = s_q.rd_valid;
    assign rd_word   = s_q.rd_word;
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int SEG_W  = 16,
    parameter int OFF_W  = 16,
    parameter int SHIFT  = 4,
    parameter int PA_W   = 20,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seg_wr_en,
    input  logic [1:0]          seg_wr_sel,
    input  logic [SEG_W-1:0]    seg_wr_data,
    input  logic                acc_valid,
    output logic                acc_ready,
    input  logic [2:0]          acc_kind,
    input  logic                ovr_en,
    input  logic [1:0]          ovr_sel,
    input  logic [OFF_W-1:0]    acc_offset,
    input  logic                acc_word,
    input  logic                acc_write,
    input  logic [2*BYTE_W-1:0] acc_wdata,
    output logic                mem_req,
    output logic [PA_W-1:0]     mem_addr,
    output logic                mem_we,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic                rd_valid,
    output logic [2*BYTE_W-1:0] rd_word
);
    logic [SEL_W-1:0] seg_sel;
    logic [SEG_W-1:0] sel_base;
    logic [SEG_W-1:0] cur_base;
    logic [OFF_W-1:0] cur_off;

    seg_select u_sel (
        .kind    (acc_kind),
        .ovr_en  (ovr_en),
        .ovr_sel (ovr_sel),
        .seg_sel (seg_sel)
    );

    seg_regfile #(.SEG_W(SEG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .rd_sel  (seg_sel),
        .rd_base (sel_base)
    );

    byte_sequencer #(
        .SEG_W  (SEG_W),
        .OFF_W  (OFF_W),
        .BYTE_W (BYTE_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_ready  (acc_ready),
        .sel_base   (sel_base),
        .acc_offset (acc_offset),
        .acc_word   (acc_word),
        .acc_write  (acc_write),
        .acc_wdata  (acc_wdata),
        .cur_base   (cur_base),
        .cur_off    (cur_off),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .rd_valid   (rd_valid),
        .rd_word    (rd_word)
    );

    phys_addr_calc #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT),
        .PA_W  (PA_W)
    ) u_pa (
        .base   (cur_base),
        .offset (cur_off),
        .paddr  (mem_addr)
    );
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
    parameter int PA_W   = 20,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_ready,
    input logic              mem_req,
    input logic              mem_ack,
    input logic              mem_we,
    input logic [PA_W-1:0]   mem_addr,
    input logic [BYTE_W-1:0] mem_wdata,
    input logic              rd_valid
);
    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R12
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ready |-> !mem_req);

    // R10
    rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R10
    rdv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(mem_req && mem_ack && !mem_we));

    // R11
    same_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (!mem_req || (mem_we == $past(mem_we))));
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.PA_W(PA_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/seg_addr_gen_test.sv
`timescale 1ns/1ps
module seg_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        acc_valid = 1'b0;
    logic        acc_ready;
    logic [2:0]  acc_kind = '0;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic [15:0] acc_offset = '0;
    logic        acc_word = 1'b0;
    logic        acc_write = 1'b0;
    logic [15:0] acc_wdata = '0;
    logic        mem_req;
    logic [19:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        rd_valid;
    logic [15:0] rd_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    seg_addr_gen uut (.*);

    function automatic logic [7:0] memf(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    task automatic seg_write(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
        @(negedge clk);
        seg_wr_en = 1'b0;
    endtask

    // one access; checks request addresses, data and the read result
    task automatic run_acc(input string req, input logic [2:0] kind, input logic oe,
                           input logic [1:0] os, input logic [15:0] off, input logic word,
                           input logic wr, input logic [15:0] wd, input logic [19:0] a0,
                           input logic [19:0] a1, input int stall, input bit poke);
        logic [7:0] b0, b1;
        @(negedge clk);
        acc_kind = kind; ovr_en = oe; ovr_sel = os; acc_offset = off;
        acc_word = word; acc_write = wr; acc_wdata = wd; acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        chk({req, " R12 busy"}, {mem_req, acc_ready}, 2'b10);
        for (int i = 0; i < stall; i++) begin
            if (poke) begin
                acc_valid = 1'b1; acc_kind = 3'd0; acc_offset = 16'h7777;
            end
            @(negedge clk);
            acc_valid = 1'b0;
            chk({req, " R9 held"}, {11'd0, mem_req, mem_addr}, {11'd0, 1'b1, a0});
        end
        chk({req, " R2 lo addr"}, {12'd0, mem_addr}, {12'd0, a0});
        chk({req, " R11 lo we/data"}, {mem_we, mem_wdata}, {wr, wr ? wd[7:0] : mem_wdata});
        b0 = memf(a0);
        mem_rdata = b0; mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        b1 = 8'h00;
        if (word) begin
            chk({req, " R8 hi addr"}, {11'd0, mem_req, mem_addr}, {11'd0, 1'b1, a1});
            chk({req, " R11 hi we/data"}, {mem_we, mem_wdata}, {wr, wr ? wd[15:8] : mem_wdata});
            b1 = memf(a1);
            mem_rdata = b1; mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
        end
        chk({req, " R10 rd_valid"}, rd_valid, !wr);
        if (!wr) chk({req, " R10 rd_word"}, rd_word, {b1, b0});
        chk({req, " R12 idle"}, {mem_req, acc_ready}, 2'b01);
        @(negedge clk);
        chk({req, " R10 pulse end"}, {rd_valid, mem_req}, 2'b00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {acc_ready, mem_req, rd_valid}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {acc_ready, mem_req, rd_valid}, 3'b100);
        run_acc("R1 zero bases", 3'd3, 0, 0, 16'h1234, 0, 0, 0, 20'h01234, 0, 0, 0);

        // R13 load bases
        seg_write(2'd0, 16'h1000);
        seg_write(2'd1, 16'h2000);
        seg_write(2'd2, 16'h3000);
        seg_write(2'd3, 16'h4000);

        // default selection
        run_acc("R3 fetch",   3'd0, 0, 0, 16'h0010, 0, 0, 0, 20'h20010, 0, 0, 0);
        run_acc("R4 stack",   3'd1, 0, 0, 16'h0022, 0, 0, 0, 20'h30022, 0, 0, 0);
        run_acc("R4 bprel",   3'd2, 0, 0, 16'h0033, 0, 0, 0, 20'h30033, 0, 0, 0);
        run_acc("R5 data",    3'd3, 0, 0, 16'h0044, 0, 0, 0, 20'h40044, 0, 0, 0);
        run_acc("R6 strdst",  3'd4, 0, 0, 16'h0055, 0, 0, 0, 20'h10055, 0, 0, 0);
        run_acc("R5 kind6",   3'd6, 0, 0, 16'h0066, 0, 0, 0, 20'h40066, 0, 0, 0);

        // overrides
        run_acc("R7 data->extra", 3'd3, 1, 2'd0, 16'h0100, 0, 0, 0, 20'h10100, 0, 0, 0);
        run_acc("R7 stack->code", 3'd1, 1, 2'd1, 16'h0200, 0, 0, 0, 20'h20200, 0, 0, 0);
        run_acc("R7 bprel->data", 3'd2, 1, 2'd3, 16'h0300, 0, 0, 0, 20'h40300, 0, 0, 0);
        run_acc("R3 fetch ovr ignored",  3'd0, 1, 2'd3, 16'h0400, 0, 0, 0, 20'h20400, 0, 0, 0);
        run_acc("R6 strdst ovr ignored", 3'd4, 1, 2'd2, 16'h0500, 0, 0, 0, 20'h10500, 0, 0, 0);

        // words
        run_acc("R8 odd word",  3'd3, 0, 0, 16'h0101, 1, 0, 0, 20'h40101, 20'h40102, 0, 0);
        run_acc("R8 even word", 3'd1, 0, 0, 16'h0F00, 1, 0, 0, 20'h30F00, 20'h30F01, 0, 0);
        run_acc("R8 offset wrap", 3'd3, 0, 0, 16'hFFFF, 1, 0, 0, 20'h4FFFF, 20'h40000, 0, 0);

        // writes
        run_acc("R11 word write", 3'd3, 0, 0, 16'h0003, 1, 1, 16'hBEEF, 20'h40003, 20'h40004, 0, 0);
        run_acc("R11 byte write", 3'd4, 0, 0, 16'h0007, 0, 1, 16'h12C3, 20'h10007, 0, 0, 0);

        // stall and ignored requests while busy
        run_acc("R9 stall", 3'd3, 0, 0, 16'h0A0A, 1, 0, 0, 20'h40A0A, 20'h40A0B, 3, 1);

        // 20-bit wrap
        seg_write(2'd3, 16'hFFFF);
        run_acc("R2 pa wrap", 3'd3, 0, 0, 16'h0020, 0, 0, 0, 20'h00010, 0, 0, 0);

        // R13 same-cycle write is not seen by that access
        @(negedge clk);
        acc_kind = 3'd3; ovr_en = 1'b0; acc_offset = 16'h0008; acc_word = 1'b0;
        acc_write = 1'b0; acc_valid = 1'b1;
        seg_wr_en = 1'b1; seg_wr_sel = 2'd3; seg_wr_data = 16'h5000;
        @(negedge clk);
        acc_valid = 1'b0; seg_wr_en = 1'b0;
        chk("R13 same-cycle old base", {12'd0, mem_addr}, {12'd0, 20'h00008 + 20'hFFFF0});
        mem_rdata = 8'h11; mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
        chk("R13 byte read", {rd_valid, rd_word}, {1'b1, 16'h0011});
        run_acc("R13 new base", 3'd3, 0, 0, 16'h0008, 0, 0, 0, 20'h50008, 0, 0, 0);

        finished = 1;
        report();
    end
endmodule